// File: doc/BRIEF.md
# Three-Wire Serial Key Device

This block is the device end of a three-wire serial key. The host controls it through an enable line, a serial clock and a single bidirectional data line. The data line is modelled here as a separate input, output and output enable. While enable is low the block does nothing. Once enable rises, the block shifts in a command word. One command code starts programming, which takes in a 64-bit identifier and then a 64-bit match word and stores both. A second code streams the stored identifier back out. Any other code parks the block in a silent stop state until enable drops.

The serial clock, enable and data pins are resynchronised into a faster system clock, and their edges are detected there, so the whole block runs in one clock domain. Input bits are taken on serial clock rising edges. Output bits are launched on falling edges. Every rising edge releases the data line. Dropping enable ends any transfer at once.

Top module: `serkey_device`

## Requirements
- R1: While `key_en_i` is low, `mode_o` reads 0 (idle), `dq_oe` is 0, and serial clock edges and data have no effect.
- R2: After `key_en_i` rises, a 24-bit command is taken least significant bit first, one bit per rising edge of `key_clk_i`. The code 24'h5A3C96 moves `mode_o` to 2 (program identifier).
- R3: Any command other than 24'h5A3C96 or 24'h3CC3A5 moves `mode_o` to 5 (stop) and sets `cmd_miss_o`. `dq_oe` then stays 0 whatever the serial clock does, until enable falls.
- R4: In program mode, 64 identifier bits and then 64 match bits are taken least significant bit first. `mode_o` reads 3 during the match word. The words appear on `id_o` and `match_o`.
- R5: When the 128th programming bit is taken, `prog_done_o` pulses high for exactly one system clock and `mode_o` becomes 5.
- R6: `id_o` and `match_o` are each replaced only once all 64 bits of their field have arrived. A transfer ended early by enable low leaves an incomplete field's register unchanged.
- R7: The command 24'h3CC3A5 moves `mode_o` to 4. The stored identifier is then driven on `dq_o`, least significant bit first, with `dq_oe` high, each bit launched by a falling edge of `key_clk_i`. After 64 bits `mode_o` becomes 5.
- R8: Every rising edge of `key_clk_i` releases the data line: `dq_oe` is 0 after each rising edge has been absorbed.
- R9: Enable low forces `dq_oe` to 0 in the same instant. It returns `mode_o` to 0 and clears `cmd_miss_o` within three system clocks.
- R10: The synchronous system reset `rst` clears `id_o`, `match_o`, `mode_o`, `dq_oe`, `prog_done_o` and `cmd_miss_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high system reset |
| key_en_i | input | 1 | Transfer enable from the host; low ends any transfer |
| key_clk_i | input | 1 | Serial clock from the host |
| dq_i | input | 1 | Data line as seen by the block |
| dq_o | output | 1 | Data value driven onto the line |
| dq_oe | output | 1 | Drive enable for the data line; 0 means high impedance |
| mode_o | output | 3 | Protocol state: 0 idle, 1 command, 2 program id, 3 program match, 4 read id, 5 stop |
| prog_done_o | output | 1 | One-cycle pulse when both programmed words are stored |
| cmd_miss_o | output | 1 | High while parked after an unknown command |
| id_o | output | 64 | Stored identifier word |
| match_o | output | 64 | Stored security match word |

## Verification
If the bit counter or state register goes wrong, `mode_o` moves at the wrong serial edge. That shows up within one serial bit period of the command or field boundary. A bad shift order or capture point surfaces as a wrong `id_o` or `match_o` word, or as a readback stream that differs from the stored identifier, at the end of the field. A fault in the abort or release logic leaves `dq_oe` high after a rising edge or after enable drops, and this is visible inside the same serial bit.

// File: rtl/serkey_pkg.sv
package serkey_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CMD      = 3'd1,
    ST_PROG_ID  = 3'd2,
    ST_PROG_SEC = 3'd3,
    ST_READ     = 3'd4,
    ST_STOP     = 3'd5
  } key_state_e;
endpackage

// File: rtl/serkey_pin_sync.sv
// Multi-stage synchroniser plus edge detection for a group of pins.
module serkey_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] stage_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/serkey_field_rx.sv
// LSB-first deserialiser; word_o is the completed word during the last shift.
module serkey_field_rx #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      sr_q  <= {bit_i, sr_q[W-1:1]};
      cnt_q <= (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(W-1));
  assign word_o = {bit_i, sr_q[W-1:1]};
endmodule

// File: rtl/serkey_device.sv
module serkey_device
  import serkey_pkg::*;
#(
  parameter int                CMD_W       = 24,
  parameter int                FIELD_W     = 64,
  parameter int                SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0]  PROG_CODE   = 24'h5A3C96,
  parameter logic [CMD_W-1:0]  READ_CODE   = 24'h3CC3A5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_en_i,
  input  logic               key_clk_i,
  input  logic               dq_i,
  output logic               dq_o,
  output logic               dq_oe,
  output logic [2:0]         mode_o,
  output logic               prog_done_o,
  output logic               cmd_miss_o,
  output logic [FIELD_W-1:0] id_o,
  output logic [FIELD_W-1:0] match_o
);
  localparam int IDX_W = $clog2(FIELD_W);

  logic [2:0] lvl, rise, fall;
  logic       en_s, dq_s, ck_rise, ck_fall;

  serkey_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({dq_i, key_clk_i, key_en_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign en_s    = lvl[0];
  assign dq_s    = lvl[2];
  assign ck_rise = rise[1];
  assign ck_fall = fall[1];

  key_state_e          st_q;
  logic [FIELD_W-1:0]  id_q, sec_q;
  logic                done_q, miss_q, oe_q, dq_q;
  logic [IDX_W-1:0]    rd_idx_q;

  logic               in_prog;
  logic [CMD_W-1:0]   cmd_word;
  logic               cmd_last;
  logic [FIELD_W-1:0] fld_word;
  logic               fld_last;

  assign in_prog = (st_q == ST_PROG_ID) || (st_q == ST_PROG_SEC);

  serkey_field_rx #(.W(CMD_W)) u_cmd_rx (
    .clk(clk), .rst(rst),
    .clr(st_q != ST_CMD),
    .shift(ck_rise && (st_q == ST_CMD)),
    .bit_i(dq_s),
    .word_o(cmd_word), .last_o(cmd_last)
  );

  serkey_field_rx #(.W(FIELD_W)) u_fld_rx (
    .clk(clk), .rst(rst),
    .clr(!in_prog),
    .shift(ck_rise && in_prog),
    .bit_i(dq_s),
    .word_o(fld_word), .last_o(fld_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      id_q     <= '0;
      sec_q    <= '0;
      done_q   <= 1'b0;
      miss_q   <= 1'b0;
      oe_q     <= 1'b0;
      dq_q     <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_s) begin
        st_q     <= ST_IDLE;
        miss_q   <= 1'b0;
        oe_q     <= 1'b0;
        rd_idx_q <= '0;
      end else begin
        if (ck_rise) oe_q <= 1'b0;
        unique case (st_q)
          ST_IDLE: st_q <= ST_CMD;
          ST_CMD: begin
            if (ck_rise && cmd_last) begin
              if (cmd_word == PROG_CODE) begin
                st_q <= ST_PROG_ID;
              end else if (cmd_word == READ_CODE) begin
                st_q     <= ST_READ;
                rd_idx_q <= '0;
              end else begin
                st_q   <= ST_STOP;
                miss_q <= 1'b1;
              end
            end
          end
          ST_PROG_ID: begin
            if (ck_rise && fld_last) begin
              id_q <= fld_word;
              st_q <= ST_PROG_SEC;
            end
          end
          ST_PROG_SEC: begin
            if (ck_rise && fld_last) begin
              sec_q  <= fld_word;
              done_q <= 1'b1;
              st_q   <= ST_STOP;
            end
          end
          ST_READ: begin
            if (ck_fall) begin
              dq_q <= id_q[rd_idx_q];
              oe_q <= 1'b1;
            end else if (ck_rise && oe_q) begin
              rd_idx_q <= rd_idx_q + 1'b1;
              if (rd_idx_q == IDX_W'(FIELD_W-1)) st_q <= ST_STOP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Raw enable gates the driver so that release is immediate.
  assign dq_oe       = oe_q & key_en_i;
  assign dq_o        = dq_q;
  assign mode_o      = st_q;
  assign prog_done_o = done_q;
  assign cmd_miss_o  = miss_q;
  assign id_o        = id_q;
  assign match_o     = sec_q;

  // R9
  en_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (st_q == ST_IDLE));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3
  miss_silent_chk: assert property (@(posedge clk) disable iff (rst)
    miss_q |-> !oe_q);

  // R7
  drive_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (st_q == ST_READ));

  // R4
  sec_after_id_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PROG_SEC) |-> ($past(st_q) == ST_PROG_ID || $past(st_q) == ST_PROG_SEC));

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_PROG_ID) |=> $stable(id_q));
endmodule

// File: tb/serkey_device_bench.sv
module serkey_device_bench;
  localparam int CLK_P = 10;
  localparam int KH    = 6;
  localparam logic [23:0] PROG = 24'h5A3C96;
  localparam logic [23:0] READ = 24'h3CC3A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_en = 1'b0;
  logic        key_clk = 1'b1;
  logic        dq_in = 1'b0;
  logic        dq_o, dq_oe, prog_done, cmd_miss;
  logic [2:0]  mode;
  logic [63:0] id_o, match_o;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  serkey_device u_serkey_device (
    .clk(clk), .rst(rst), .key_en_i(key_en), .key_clk_i(key_clk), .dq_i(dq_in),
    .dq_o(dq_o), .dq_oe(dq_oe), .mode_o(mode), .prog_done_o(prog_done),
    .cmd_miss_o(cmd_miss), .id_o(id_o), .match_o(match_o)
  );

  always @(negedge clk) if (prog_done) done_cnt++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int k);
    if (k == 0) return 64'h0;
    if (k == 1) return '1;
    if (k == 2) return 64'h5555_5555_5555_5555;
    return {32'(k * 32'h9E3779B9), 32'(k * 32'h85EBCA6B)};
  endfunction

  task automatic send_bit(input logic b);
    dq_in = b;
    key_clk = 1'b0;
    repeat (KH) @(negedge clk);
    key_clk = 1'b1;
    repeat (KH) @(negedge clk);
  endtask

  task automatic send_word(input logic [63:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic begin_xfer();
    key_en = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic end_xfer();
    key_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_id(output logic [63:0] got, output bit oe_hi_ok, output bit oe_lo_ok);
    oe_hi_ok = 1'b1;
    oe_lo_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      key_clk = 1'b0;
      repeat (KH) @(negedge clk);
      if (dq_oe !== 1'b1) oe_hi_ok = 1'b0;
      got[i] = dq_o;
      key_clk = 1'b1;
      repeat (KH) @(negedge clk);
      if (dq_oe !== 1'b0) oe_lo_ok = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] exp_id, exp_sec, got;
    bit hi_ok, lo_ok, oe_seen;
    int d0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(mode == 3'd0 && dq_oe == 1'b0 && !prog_done && !cmd_miss, "R10 reset status", {61'd0, mode}, 64'd0);
    chk(id_o == 64'd0 && match_o == 64'd0, "R10 reset words", id_o | match_o, 64'd0);
    exp_id = '0;
    exp_sec = '0;

    // R1: clocks with enable low are ignored
    send_word(64'h00000000005A3C96, 24);
    send_word(64'hFFFF_0000_1234_ABCD, 40);
    chk(mode == 3'd0 && dq_oe == 1'b0, "R1 idle while disabled", {61'd0, mode}, 64'd0);
    chk(id_o == exp_id && match_o == exp_sec, "R1 words untouched", id_o, exp_id);

    // R3: unknown command
    begin_xfer();
    chk(mode == 3'd1, "R2 command state", {61'd0, mode}, 64'd1);
    send_word(64'h123456, 24);
    chk(mode == 3'd5 && cmd_miss == 1'b1, "R3 mismatch stop", {60'd0, cmd_miss, mode}, {60'd0, 1'b1, 3'd5});
    oe_seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      key_clk = 1'b0;
      repeat (KH) @(negedge clk);
      if (dq_oe) oe_seen = 1'b1;
      key_clk = 1'b1;
      repeat (KH) @(negedge clk);
      if (dq_oe) oe_seen = 1'b1;
    end
    chk(!oe_seen && mode == 3'd5, "R3 silent in stop", {63'd0, oe_seen}, 64'd0);
    end_xfer();
    // R9 return to idle
    chk(mode == 3'd0 && cmd_miss == 1'b0, "R9 idle after enable low", {60'd0, cmd_miss, mode}, 64'd0);

    // Sweep of programming and readback patterns
    for (int k = 0; k < 8; k++) begin
      logic [63:0] nid, nsec;
      nid  = pat(k);
      nsec = ~pat(k + 3) ^ {pat(k)[31:0], pat(k)[63:32]};
      begin_xfer();
      send_word({40'd0, PROG}, 24);
      chk(mode == 3'd2, "R2 program entered", {61'd0, mode}, 64'd2);
      send_word(nid, 64);
      exp_id = nid;
      chk(mode == 3'd3 && id_o == exp_id, "R4 identifier stored", id_o, exp_id);
      chk(match_o == exp_sec, "R6 match held until complete", match_o, exp_sec);
      d0 = done_cnt;
      send_word(nsec, 64);
      exp_sec = nsec;
      chk(match_o == exp_sec, "R4 match stored", match_o, exp_sec);
      chk(mode == 3'd5 && done_cnt == d0 + 1, "R5 done pulse and stop", {32'(done_cnt - d0), 29'd0, mode}, {32'd1, 29'd0, 3'd5});
      end_xfer();

      begin_xfer();
      send_word({40'd0, READ}, 24);
      chk(mode == 3'd4, "R7 read entered", {61'd0, mode}, 64'd4);
      read_id(got, hi_ok, lo_ok);
      chk(got == exp_id, "R7 readback data", got, exp_id);
      chk(hi_ok, "R7 drive after falling edge", {63'd0, hi_ok}, 64'd1);
      chk(lo_ok, "R8 release after rising edge", {63'd0, lo_ok}, 64'd1);
      chk(mode == 3'd5, "R7 stop after 64 bits", {61'd0, mode}, 64'd5);
      end_xfer();
    end

    // R6: abort inside identifier field
    begin_xfer();
    send_word({40'd0, PROG}, 24);
    send_word(64'hDEAD_BEEF_CAFE_F00D, 30);
    end_xfer();
    chk(id_o == exp_id && match_o == exp_sec, "R6 partial id discarded", id_o, exp_id);
    chk(mode == 3'd0, "R9 idle after abort", {61'd0, mode}, 64'd0);

    // R6: abort inside match field after full identifier
    begin_xfer();
    send_word({40'd0, PROG}, 24);
    send_word(64'h0F1E_2D3C_4B5A_6978, 64);
    exp_id = 64'h0F1E_2D3C_4B5A_6978;
    send_word(64'h1111_2222_3333_4444, 10);
    end_xfer();
    chk(id_o == exp_id, "R6 complete id kept", id_o, exp_id);
    chk(match_o == exp_sec, "R6 partial match discarded", match_o, exp_sec);

    // R9: enable drop while driving
    begin_xfer();
    send_word({40'd0, READ}, 24);
    key_clk = 1'b0;
    repeat (KH) @(negedge clk);
    chk(dq_oe == 1'b1 && dq_o == exp_id[0], "R7 first bit driven", {62'd0, dq_oe, dq_o}, {62'd0, 1'b1, exp_id[0]});
    key_en = 1'b0;
    #1;
    chk(dq_oe == 1'b0, "R9 immediate release", {63'd0, dq_oe}, 64'd0);
    key_clk = 1'b1;
    repeat (6) @(negedge clk);
    chk(mode == 3'd0 && dq_oe == 1'b0, "R9 idle after read abort", {61'd0, mode}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule